// File: doc/BRIEF.md
# Bus Write Trace Logger

The block watches write traffic from three bus masters: a main processor, a low-power processor and a DMA engine. Every cycle each snoop port may present one write: address, data and access size. A write is selected when its source is enabled, its address lies in a programmed window and the one-hot mode accepts it. One mode accepts every write. The other three modes accept only one access size, and only when the data equals a programmed pattern on the bytes that are not masked out.

Each selected write becomes a two-word log record. The block emits the record on a simple memory-write master port, into a ring region bounded by a base address and an end address. The next free address in the ring is always visible on an output. A one-cycle pulse reloads that pointer with the base. When the ring runs out of room, the pointer either wraps to the base and sets a sticky flag, or, with wrapping off, stays put while further records are discarded. A one-cycle pulse clears the sticky flag.

Configuration arrives on plain level inputs, the way a register bank would drive them.

Top module: `bus_write_tracer`

## Requirements
- R1: After reset, next_ptr is 0, wrapped is 0 and lw_valid is 0.
- R2: cfg_mode must be one-hot. 4'b0001 logs every write of any size. Any value that is not one-hot logs nothing.
- R3: A write is considered only when cfg_win_lo <= address <= cfg_win_hi. Both bounds are inclusive.
- R4: cfg_src_en bit 0 enables source 0 (main processor), bit 1 enables source 1 (low-power processor) and bit 2 enables source 2 (DMA). Writes from a disabled source produce no record.
- R5: Access size codes are 0 = byte, 1 = halfword and 2 = word. Mode 4'b0010 accepts only word writes, 4'b0100 only halfword writes and 4'b1000 only byte writes. In each of these modes the data must also equal cfg_pattern.
- R6: When cfg_byte_ign bit k is set, data bits [8k+7:8k] take no part in the pattern comparison.
- R7: A record is two consecutive lw_valid beats. The first goes to next_ptr and carries the write address. The second goes to next_ptr+4 and carries the source number in bits [9:8] and the size code in bits [1:0]. next_ptr then advances by 8. The first beat appears in the second cycle after the cycle in which the write was snooped.
- R8: When several sources are selected together, each is held in a one-deep pending slot. Records go out in the order source 0, then source 1, then source 2.
- R9: A record is written only if it fits entirely below cfg_ring_end, i.e. ptr+8 <= cfg_ring_end. With cfg_wrap_en = 1, an advance that leaves no room for another record sets next_ptr to cfg_ring_base and sets wrapped.
- R10: wrapped stays set until a wrap_clr pulse clears it.
- R11: With cfg_wrap_en = 0, a record that does not fit is discarded and next_ptr keeps its value.
- R12: A ptr_reload pulse loads next_ptr with cfg_ring_base on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_src_en | input | 3 | Per-source enable |
| cfg_mode | input | 4 | One-hot trigger mode |
| cfg_wrap_en | input | 1 | Ring wrap enable |
| cfg_pattern | input | 32 | Data pattern for the compare modes |
| cfg_byte_ign | input | 4 | Per-byte exclusion from the compare |
| cfg_win_lo | input | 32 | Lowest address watched |
| cfg_win_hi | input | 32 | Highest address watched |
| cfg_ring_base | input | 32 | First address of the log ring |
| cfg_ring_end | input | 32 | Exclusive upper limit of the log ring |
| ptr_reload | input | 1 | Pulse: pointer takes the ring base |
| wrap_clr | input | 1 | Pulse: clear the wrapped flag |
| snp_valid | input | 3 | Per-source write strobe |
| snp_addr | input | 96 | Per-source write address, source s at [32s+31:32s] |
| snp_data | input | 96 | Per-source write data, source s at [32s+31:32s] |
| snp_size | input | 6 | Per-source size code, source s at [2s+1:2s] |
| lw_valid | output | 1 | Log write strobe |
| lw_addr | output | 32 | Log write address |
| lw_data | output | 32 | Log write data |
| next_ptr | output | 32 | Next ring address to be written |
| wrapped | output | 1 | Sticky wrap indicator |

## Verification
A corrupted pending slot or a wrong priority choice shows up within a few record times. The second beats of a burst then carry source numbers out of order, or too few records appear. A wrong pointer update appears on next_ptr at the next clock edge, and on lw_addr at the start of the following record. A stale wrap decision shows as next_ptr stepping past the ring end, or as wrapped not rising, right after the last record that fits.

// File: rtl/wtl_pkg.sv
package wtl_pkg;
  // access size codes on the snoop ports
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } wtl_size_e;

  localparam logic [3:0] MODE_ANY  = 4'b0001;
  localparam logic [3:0] MODE_WORD = 4'b0010;
  localparam logic [3:0] MODE_HALF = 4'b0100;
  localparam logic [3:0] MODE_BYTE = 4'b1000;

  localparam int unsigned REC_BYTES = 8;  // two 32-bit beats per record
  localparam int unsigned SRC_LSB   = 8;  // source number position in beat 2
endpackage

// File: rtl/wtl_match.sv
module wtl_match
  import wtl_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  localparam int unsigned NB = DW / 8
) (
  input  logic          en,
  input  logic          valid,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic [1:0]    size,
  input  logic [3:0]    mode,
  input  logic [DW-1:0] pattern,
  input  logic [NB-1:0] byte_ign,
  input  logic [AW-1:0] win_lo,
  input  logic [AW-1:0] win_hi,
  output logic          hit
);
  function automatic logic masked_eq(logic [DW-1:0] d, logic [DW-1:0] p,
                                     logic [NB-1:0] ign);
    for (int b = 0; b < NB; b++)
      if (!ign[b] && d[8*b +: 8] != p[8*b +: 8]) return 1'b0;
    return 1'b1;
  endfunction

  logic in_win, size_sel, pat_ok;

  always_comb begin
    in_win   = (addr >= win_lo) && (addr <= win_hi);
    size_sel = (mode == MODE_WORD && size == SZ_WORD) ||
               (mode == MODE_HALF && size == SZ_HALF) ||
               (mode == MODE_BYTE && size == SZ_BYTE);
    pat_ok   = masked_eq(data, pattern, byte_ign);
    hit      = en && valid && in_win && ((mode == MODE_ANY) || (size_sel && pat_ok));
  end
endmodule

// File: rtl/wtl_arb.sv
module wtl_arb #(
  parameter int unsigned NSRC = 3,
  parameter int unsigned AW   = 32,
  localparam int unsigned SW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  hit,
  input  logic [NSRC*AW-1:0] addr,
  input  logic [2*NSRC-1:0]  size,
  input  logic             take,
  output logic             gnt_vld,
  output logic [SW-1:0]    gnt_src,
  output logic [AW-1:0]    gnt_addr,
  output logic [1:0]       gnt_size
);
  logic [NSRC-1:0]    pend;
  logic [NSRC-1:0]    gnt_oh;
  logic [NSRC*AW-1:0] pend_addr;
  logic [2*NSRC-1:0]  pend_size;
  logic               found;

  // lowest source number wins
  always_comb begin
    found   = 1'b0;
    gnt_src = '0;
    for (int i = 0; i < NSRC; i++)
      if (!found && pend[i]) begin
        found   = 1'b1;
        gnt_src = SW'(i);
      end
    gnt_vld  = take && found;
    gnt_oh   = gnt_vld ? (NSRC'(1) << gnt_src) : '0;
    gnt_addr = pend_addr[gnt_src*AW +: AW];
    gnt_size = pend_size[gnt_src*2 +: 2];
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_slot
    logic          pv;
    logic [AW-1:0] pa;
    logic [1:0]    ps;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pv <= 1'b0;
        pa <= '0;
        ps <= '0;
      end else if (hit[i] && (!pv || gnt_oh[i])) begin
        pv <= 1'b1;
        pa <= addr[i*AW +: AW];
        ps <= size[i*2 +: 2];
      end else if (gnt_oh[i]) begin
        pv <= 1'b0;
      end
    end
    assign pend[i]               = pv;
    assign pend_addr[i*AW +: AW] = pa;
    assign pend_size[i*2 +: 2]   = ps;

    if (i > 0) begin : g_prio
      a_r8_lower_first: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_oh[i] |-> (pend[i-1:0] == '0));
    end
  end

  a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_oh));
endmodule

// File: rtl/wtl_ring.sv
module wtl_ring
  import wtl_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gnt_vld,
  input  logic [SW-1:0] gnt_src,
  input  logic [AW-1:0] gnt_addr,
  input  logic [1:0]    gnt_size,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_end,
  input  logic          cfg_wrap_en,
  input  logic          ptr_reload,
  input  logic          wrap_clr,
  output logic          take,
  output logic          lw_valid,
  output logic [AW-1:0] lw_addr,
  output logic [DW-1:0] lw_data,
  output logic [AW-1:0] next_ptr,
  output logic          wrapped
);
  localparam logic [AW:0] REC_EXT = (AW+1)'(REC_BYTES);

  function automatic logic rec_fits(logic [AW-1:0] p, logic [AW-1:0] e);
    return ({1'b0, p} + REC_EXT) <= {1'b0, e};
  endfunction

  typedef enum logic [1:0] {ST_IDLE, ST_B0, ST_B1} st_e;

  st_e           st;
  logic [AW-1:0] ptr, rec_addr, ptr_inc;
  logic [SW-1:0] rec_src;
  logic [1:0]    rec_size;
  logic          flag;
  logic          start_ev, adv_ev, wrap_ev;

  assign ptr_inc  = ptr + AW'(REC_BYTES);
  assign take     = (st == ST_IDLE);
  assign start_ev = take && gnt_vld && rec_fits(ptr, cfg_end);
  assign adv_ev   = (st == ST_B1) && !ptr_reload;
  assign wrap_ev  = adv_ev && cfg_wrap_en && !rec_fits(ptr_inc, cfg_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ptr      <= '0;
      flag     <= 1'b0;
      rec_addr <= '0;
      rec_src  <= '0;
      rec_size <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start_ev) begin
          st       <= ST_B0;
          rec_addr <= gnt_addr;
          rec_src  <= gnt_src;
          rec_size <= gnt_size;
        end
        ST_B0:   st <= ST_B1;
        default: st <= ST_IDLE;
      endcase
      if (ptr_reload)   ptr <= cfg_base;
      else if (wrap_ev) ptr <= cfg_base;
      else if (adv_ev)  ptr <= ptr_inc;
      if (wrap_ev)       flag <= 1'b1;
      else if (wrap_clr) flag <= 1'b0;
    end
  end

  always_comb begin
    lw_valid = (st != ST_IDLE);
    lw_addr  = (st == ST_B1) ? ptr + AW'(4) : ptr;
    lw_data  = '0;
    if (st == ST_B1) begin
      lw_data[SRC_LSB +: SW] = rec_src;
      lw_data[1:0]           = rec_size;
    end else begin
      lw_data = DW'(rec_addr);
    end
  end

  assign next_ptr = ptr;
  assign wrapped  = flag;

  a_r7_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_B0 && !ptr_reload) |=> (lw_valid && lw_addr == $past(lw_addr) + AW'(4)));
  a_r9_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> (next_ptr == $past(cfg_base) && wrapped));
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wrapped && !wrap_clr) |=> wrapped);
  a_r11_idle_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ptr_reload) |=> (next_ptr == $past(next_ptr)));
  a_r12_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_reload |=> (next_ptr == $past(cfg_base)));
endmodule

// File: rtl/bus_write_tracer.sv
module bus_write_tracer #(
  parameter int unsigned NSRC = 3,
  parameter int unsigned AW   = 32,
  parameter int unsigned DW   = 32,
  localparam int unsigned NB  = DW / 8,
  localparam int unsigned SW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    cfg_src_en,
  input  logic [3:0]         cfg_mode,
  input  logic               cfg_wrap_en,
  input  logic [DW-1:0]      cfg_pattern,
  input  logic [NB-1:0]      cfg_byte_ign,
  input  logic [AW-1:0]      cfg_win_lo,
  input  logic [AW-1:0]      cfg_win_hi,
  input  logic [AW-1:0]      cfg_ring_base,
  input  logic [AW-1:0]      cfg_ring_end,
  input  logic               ptr_reload,
  input  logic               wrap_clr,
  input  logic [NSRC-1:0]    snp_valid,
  input  logic [NSRC*AW-1:0] snp_addr,
  input  logic [NSRC*DW-1:0] snp_data,
  input  logic [2*NSRC-1:0]  snp_size,
  output logic               lw_valid,
  output logic [AW-1:0]      lw_addr,
  output logic [DW-1:0]      lw_data,
  output logic [AW-1:0]      next_ptr,
  output logic               wrapped
);
  logic [NSRC-1:0] hit;
  logic            take, gnt_vld;
  logic [SW-1:0]   gnt_src;
  logic [AW-1:0]   gnt_addr;
  logic [1:0]      gnt_size;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    wtl_match #(.AW(AW), .DW(DW)) match_i (
      .en(cfg_src_en[s]), .valid(snp_valid[s]),
      .addr(snp_addr[s*AW +: AW]), .data(snp_data[s*DW +: DW]),
      .size(snp_size[s*2 +: 2]), .mode(cfg_mode),
      .pattern(cfg_pattern), .byte_ign(cfg_byte_ign),
      .win_lo(cfg_win_lo), .win_hi(cfg_win_hi), .hit(hit[s])
    );
  end

  wtl_arb #(.NSRC(NSRC), .AW(AW)) arb_i (
    .clk(clk), .rst_n(rst_n), .hit(hit), .addr(snp_addr), .size(snp_size),
    .take(take), .gnt_vld(gnt_vld), .gnt_src(gnt_src),
    .gnt_addr(gnt_addr), .gnt_size(gnt_size)
  );

  wtl_ring #(.AW(AW), .DW(DW), .SW(SW)) ring_i (
    .clk(clk), .rst_n(rst_n), .gnt_vld(gnt_vld), .gnt_src(gnt_src),
    .gnt_addr(gnt_addr), .gnt_size(gnt_size), .cfg_base(cfg_ring_base),
    .cfg_end(cfg_ring_end), .cfg_wrap_en(cfg_wrap_en), .ptr_reload(ptr_reload),
    .wrap_clr(wrap_clr), .take(take), .lw_valid(lw_valid), .lw_addr(lw_addr),
    .lw_data(lw_data), .next_ptr(next_ptr), .wrapped(wrapped)
  );

  a_r2_mode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |-> $onehot(cfg_mode));
  a_r4_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit & ~cfg_src_en) == '0));
endmodule

// File: tb/bus_write_tracer_tb_top.sv
module bus_write_tracer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_src_en = 3'b111;
  logic [3:0]  cfg_mode = 4'b0001;
  logic        cfg_wrap_en = 1'b1;
  logic [31:0] cfg_pattern = '0;
  logic [3:0]  cfg_byte_ign = '0;
  logic [31:0] cfg_win_lo = 32'h2000, cfg_win_hi = 32'h2FFF;
  logic [31:0] cfg_ring_base = 32'h1000, cfg_ring_end = 32'h1020;
  logic        ptr_reload = 1'b0, wrap_clr = 1'b0;
  logic [2:0]  snp_valid = '0;
  logic [95:0] snp_addr = '0, snp_data = '0;
  logic [5:0]  snp_size = '0;
  logic        lw_valid, wrapped;
  logic [31:0] lw_addr, lw_data, next_ptr;

  int nchk = 0, nfail = 0, ncap = 0;
  logic [31:0] cap_a [64];
  logic [31:0] cap_d [64];

  always #2 clk = ~clk;

  bus_write_tracer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_src_en(cfg_src_en), .cfg_mode(cfg_mode),
    .cfg_wrap_en(cfg_wrap_en), .cfg_pattern(cfg_pattern), .cfg_byte_ign(cfg_byte_ign),
    .cfg_win_lo(cfg_win_lo), .cfg_win_hi(cfg_win_hi), .cfg_ring_base(cfg_ring_base),
    .cfg_ring_end(cfg_ring_end), .ptr_reload(ptr_reload), .wrap_clr(wrap_clr),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_data(snp_data),
    .snp_size(snp_size), .lw_valid(lw_valid), .lw_addr(lw_addr),
    .lw_data(lw_data), .next_ptr(next_ptr), .wrapped(wrapped)
  );

  // record every log beat, sampled mid-cycle
  always @(negedge clk)
    if (rst_n && lw_valid && ncap < 64) begin
      cap_a[ncap] = lw_addr;
      cap_d[ncap] = lw_data;
      ncap++;
    end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic snoop(int s, logic [31:0] a, logic [31:0] d, logic [1:0] sz);
    @(negedge clk);
    snp_valid[s] = 1'b1;
    snp_addr[s*32 +: 32] = a;
    snp_data[s*32 +: 32] = d;
    snp_size[s*2 +: 2] = sz;
    @(negedge clk);
    snp_valid = '0;
    repeat (6) @(negedge clk);
  endtask

  task automatic reload_ptr();
    @(negedge clk); ptr_reload = 1'b1;
    @(negedge clk); ptr_reload = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); wrap_clr = 1'b1;
    @(negedge clk); wrap_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 next_ptr", next_ptr, 32'h0);
    chk("R1 wrapped", {31'b0, wrapped}, 32'h0);
    chk("R1 lw_valid", {31'b0, lw_valid}, 32'h0);
    reload_ptr();
    chk("R12 reload", next_ptr, 32'h1000);
  endtask

  task automatic t_any_mode();
    int b = ncap;
    snoop(0, 32'h2010, 32'h55, 2'd0);
    chk("R2 any-mode beats", ncap - b, 2);
    chk("R7 beat1 addr", cap_a[b], 32'h1000);
    chk("R7 beat1 data", cap_d[b], 32'h2010);
    chk("R7 beat2 addr", cap_a[b+1], 32'h1004);
    chk("R7 beat2 data", cap_d[b+1], 32'h0000_0000);
    chk("R7 ptr step", next_ptr, 32'h1008);
    b = ncap;
    snoop(1, 32'h2FFF, 32'h1234, 2'd1);
    chk("R3 upper bound inclusive", ncap - b, 2);
    chk("R7 src/size field", cap_d[b+1], 32'h0000_0101);
    b = ncap;
    snoop(2, 32'h2000, 32'h0, 2'd2);
    chk("R3 lower bound inclusive", ncap - b, 2);
  endtask

  task automatic t_window();
    int b = ncap;
    logic [31:0] p = next_ptr;
    snoop(0, 32'h1FFF, 32'h1, 2'd2);
    snoop(0, 32'h3000, 32'h1, 2'd2);
    chk("R3 outside window", ncap - b, 0);
    chk("R3 ptr unchanged", next_ptr, p);
  endtask

  task automatic t_enable();
    int b;
    reload_ptr();
    cfg_src_en = 3'b001;
    b = ncap;
    snoop(2, 32'h2020, 32'h0, 2'd2);
    snoop(1, 32'h2020, 32'h0, 2'd2);
    chk("R4 disabled sources", ncap - b, 0);
    chk("R4 ptr unchanged", next_ptr, 32'h1000);
    cfg_src_en = 3'b100;
    b = ncap;
    snoop(2, 32'h2024, 32'h0, 2'd0);
    chk("R4 dma enabled", ncap - b, 2);
    chk("R4 dma id", cap_d[b+1], 32'h0000_0200);
    cfg_src_en = 3'b111;
  endtask

  task automatic t_compare();
    int b;
    reload_ptr();
    cfg_pattern = 32'hDEADBEEF;
    cfg_mode = 4'b0010;
    b = ncap; snoop(0, 32'h2100, 32'hDEADBEEF, 2'd2);
    chk("R5 word match", ncap - b, 2);
    b = ncap; snoop(0, 32'h2100, 32'hDEADBEEE, 2'd2);
    chk("R5 word mismatch", ncap - b, 0);
    b = ncap; snoop(0, 32'h2100, 32'hDEADBEEF, 2'd1);
    chk("R5 size filter", ncap - b, 0);
    cfg_mode = 4'b0100;
    b = ncap; snoop(1, 32'h2102, 32'hDEADBEEF, 2'd1);
    chk("R5 half match", ncap - b, 2);
    cfg_mode = 4'b1000;
    b = ncap; snoop(1, 32'h2103, 32'hDEADBEEF, 2'd0);
    chk("R5 byte match", ncap - b, 2);
    cfg_mode = 4'b0011;
    b = ncap; snoop(0, 32'h2100, 32'hDEADBEEF, 2'd2);
    chk("R2 non-onehot mode", ncap - b, 0);
    cfg_mode = 4'b0010;
    cfg_byte_ign = 4'b0011;
    b = ncap; snoop(0, 32'h2104, 32'hDEAD1234, 2'd2);
    chk("R6 low bytes ignored", ncap - b, 2);
    b = ncap; snoop(0, 32'h2104, 32'hDEAF0000, 2'd2);
    chk("R6 high bytes compared", ncap - b, 0);
    cfg_byte_ign = '0;
    cfg_mode = 4'b0001;
  endtask

  task automatic t_priority();
    int b;
    reload_ptr();
    b = ncap;
    @(negedge clk);
    snp_valid = 3'b111;
    snp_addr = {32'h2300, 32'h2200, 32'h2100};
    snp_size = {2'd2, 2'd1, 2'd0};
    @(negedge clk);
    snp_valid = '0;
    chk("R7 no beat yet", {31'b0, lw_valid}, 32'h0);
    @(negedge clk);
    chk("R7 first beat latency", {31'b0, lw_valid}, 32'h1);
    chk("R7 first beat addr", lw_addr, 32'h1000);
    repeat (14) @(negedge clk);
    chk("R8 all kept", ncap - b, 6);
    chk("R8 order 0", cap_d[b+1], 32'h0000_0000);
    chk("R8 order 1", cap_d[b+3], 32'h0000_0101);
    chk("R8 order 2", cap_d[b+5], 32'h0000_0202);
    chk("R8 third addr", cap_d[b+4], 32'h2300);
  endtask

  task automatic t_wrap();
    int b;
    cfg_wrap_en = 1'b1;
    reload_ptr();
    clear_flag();
    for (int k = 0; k < 3; k++) snoop(0, 32'h2400, 32'h0, 2'd2);
    chk("R9 before wrap ptr", next_ptr, 32'h1018);
    chk("R9 before wrap flag", {31'b0, wrapped}, 32'h0);
    snoop(0, 32'h2400, 32'h0, 2'd2);
    chk("R9 wrap ptr", next_ptr, 32'h1000);
    chk("R9 wrap flag", {31'b0, wrapped}, 32'h1);
    b = ncap;
    snoop(0, 32'h2408, 32'h0, 2'd2);
    chk("R9 after wrap addr", cap_a[b], 32'h1000);
    chk("R10 flag sticky", {31'b0, wrapped}, 32'h1);
    clear_flag();
    chk("R10 flag cleared", {31'b0, wrapped}, 32'h0);
  endtask

  task automatic t_no_wrap();
    int b;
    cfg_wrap_en = 1'b0;
    reload_ptr();
    for (int k = 0; k < 4; k++) snoop(1, 32'h2500, 32'h0, 2'd2);
    chk("R11 ptr at end", next_ptr, 32'h1020);
    b = ncap;
    snoop(1, 32'h2500, 32'h0, 2'd2);
    chk("R11 record dropped", ncap - b, 0);
    chk("R11 ptr held", next_ptr, 32'h1020);
    chk("R11 no flag", {31'b0, wrapped}, 32'h0);
    reload_ptr();
    chk("R12 reload after stop", next_ptr, 32'h1000);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #400000;
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_any_mode();
    t_window();
    t_enable();
    t_compare();
    t_priority();
    t_wrap();
    t_no_wrap();
    finish_run();
  end
endmodule